// File: doc/BRIEF.md
# Source-Routed Wormhole Input Port

This block is the receive side of one switch input in a network where every packet carries its own route. The sender places the output-port number for each switch on the path into the first flit, one small field per hop, lowest field first. On arrival of that first flit the port decodes the lowest field and shifts the header right so that the next switch finds its own field in the same place. It then claims the chosen output for the rest of the packet. The switch itself holds no routing table; its only routing state is the port of the packet that is passing through.

Forwarding starts as soon as the head flit is in the stage. The head does not wait for the rest of the packet. Each flit moves on only when the output arbiter grants the claimed output and the downstream side is ready. When either is missing, the flit stays where it is and the input stalls. The packet therefore stays spread across the switches it already occupies, and its tail is never gathered. The claimed output is given up on the transfer of the flit that carries the tail marker.

Top module: `srp_inport`

## Requirements
- R1: After reset, `out_valid` is 0, `req_vec` is all zero and `in_ready` is 1.
- R2: When a head flit opens a path, bits [PORT_W-1:0] of its data select the output port. From the next cycle, `req_vec` has exactly that one bit set, and it keeps it until the tail flit is transferred.
- R3: The head flit that opens a path is forwarded with its data shifted right by PORT_W bits, with zeros entering at the top.
- R4: While a path is locked, every further flit is forwarded with its data unchanged, on the same port. This includes a flit whose head bit is set.
- R5: The flit type uses bit 0 as the head marker and bit 1 as the tail marker (00 body, 01 head, 10 tail, 11 single-flit packet). It is forwarded unchanged.
- R6: A flit is transferred only in a cycle where `out_valid`, `grant_vec[out_port]` and `out_ready` are all 1. Until then `out_data`, `out_type` and `out_port` hold their values. A grant on any other port has no effect.
- R7: The path is released by the transfer of the tail flit. `req_vec` is zero in the next cycle unless a new head was accepted in that same cycle.
- R8: A single-flit packet (type 11) locks the path when it is accepted, is forwarded stripped, and releases the path on its own transfer.
- R9: A body or tail flit that arrives while no path is locked, counting a path being released in that cycle as not locked, is accepted and discarded. Nothing is forwarded for it.
- R10: `in_ready` is 1 when the stage is empty or a transfer happens in that cycle. This sustains one flit per cycle.
- R11: `out_port` shows the port decoded from the head of the packet the forwarded flit belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream flit present |
| in_ready | output | 1 | Port accepts the offered flit this cycle |
| in_type | input | 2 | Flit type, bit 0 head, bit 1 tail |
| in_data | input | FLIT_W | Flit payload; on a head, route fields from bit 0 upward |
| req_vec | output | 2**PORT_W | One-hot request for the locked output |
| grant_vec | input | 2**PORT_W | Grant from the output arbiters |
| out_valid | output | 1 | Forwarded flit present |
| out_ready | input | 1 | Downstream accepts a flit |
| out_type | output | 2 | Forwarded flit type |
| out_data | output | FLIT_W | Forwarded payload, stripped on the head |
| out_port | output | PORT_W | Output the forwarded flit is routed to |

## Verification
The bench targets the cycle where a tail leaves while a new head arrives. A design that releases the path one cycle late would route that head with the old port or hold off its request. It also sends stray body and tail flits with no path open; a design that forwards them would put flits on a stale port. Long runs with a grant given to the wrong output show whether a design looks at the grant of its own port only; one that ORs the whole grant vector would advance a frozen packet. Head-marked flits inside a locked packet check that only the opening head is stripped, since stripping every flit with the head bit set would corrupt the payload.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // flit type bit positions
  localparam int unsigned TYPE_W   = 2;
  localparam int unsigned HEAD_BIT = 0;
  localparam int unsigned TAIL_BIT = 1;

  typedef logic [TYPE_W-1:0] ftype_t;

  function automatic logic is_head(input ftype_t t);
    return t[HEAD_BIT];
  endfunction

  function automatic logic is_tail(input ftype_t t);
    return t[TAIL_BIT];
  endfunction
endpackage

// File: rtl/srp_hdr_strip.sv
module srp_hdr_strip #(
  parameter int unsigned FLIT_W = 32,
  parameter int unsigned PORT_W = 4
) (
  input  logic [FLIT_W-1:0] hdr_i,
  output logic [PORT_W-1:0] port_o,
  output logic [FLIT_W-1:0] rest_o
);
  localparam int unsigned KEEP_W = FLIT_W - PORT_W;

  assign port_o = hdr_i[PORT_W-1:0];
  assign rest_o = {{PORT_W{1'b0}}, hdr_i[FLIT_W-1:PORT_W]};

  initial begin
    if (KEEP_W < 1) $error("flit too narrow for one route field");
  end
endmodule

// File: rtl/srp_path_lock.sv
module srp_path_lock #(
  parameter int unsigned PORT_W = 4,
  localparam int unsigned NPORTS = 1 << PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic [PORT_W-1:0] open_port_i,
  input  logic              close_i,
  output logic              locked_o,
  output logic [PORT_W-1:0] port_o,
  output logic [NPORTS-1:0] req_o
);
  logic [NPORTS-1:0] dec;

  for (genvar g = 0; g < NPORTS; g++) begin : g_dec
    assign dec[g] = (open_port_i == PORT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b0;
      port_o   <= '0;
      req_o    <= '0;
    end else if (open_i) begin
      locked_o <= 1'b1;
      port_o   <= open_port_i;
      req_o    <= dec;
    end else if (close_i) begin
      locked_o <= 1'b0;
      req_o    <= '0;
    end
  end

  // R2: at most one output requested
  p_req_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_o));

  // R7: a new path opens only when idle or releasing
  p_open_free_r7: assert property (@(posedge clk) disable iff (rst)
    open_i |-> (!locked_o || close_i));

  // R2: request follows lock state
  p_req_lock_r2: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> (req_o != '0));
endmodule

// File: rtl/srp_flit_stage.sv
module srp_flit_stage #(
  parameter int unsigned FLIT_W = 32,
  parameter int unsigned TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [FLIT_W-1:0] data_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [FLIT_W-1:0] data_o,
  output logic [TYPE_W-1:0] type_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      type_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      type_o  <= type_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10: never overwrite a held flit that is not leaving
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (rst)
    !(load_i && valid_o && !pop_i));

  // R6: a stalled flit stays in place
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o) && $stable(type_o)));
endmodule

// File: rtl/srp_inport.sv
module srp_inport #(
  parameter int unsigned FLIT_W = 32,
  parameter int unsigned PORT_W = 4,
  localparam int unsigned NPORTS = 1 << PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_type,
  input  logic [FLIT_W-1:0] in_data,
  output logic [NPORTS-1:0] req_vec,
  input  logic [NPORTS-1:0] grant_vec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_type,
  output logic [FLIT_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port
);
  import srp_pkg::*;

  logic [PORT_W-1:0] hdr_port;
  logic [FLIT_W-1:0] hdr_rest;
  logic              locked;
  logic              fire, closing, lock_after, accept, opening, load;
  logic [FLIT_W-1:0] ld_data;

  srp_hdr_strip #(.FLIT_W(FLIT_W), .PORT_W(PORT_W)) u_strip (
    .hdr_i  (in_data),
    .port_o (hdr_port),
    .rest_o (hdr_rest)
  );

  assign fire       = out_valid && out_ready && grant_vec[out_port];
  assign closing    = fire && is_tail(out_type);
  assign lock_after = locked && !closing;
  assign in_ready   = !out_valid || fire;
  assign accept     = in_valid && in_ready;
  assign opening    = accept && !lock_after && is_head(in_type);
  assign load       = accept && (lock_after || is_head(in_type));
  assign ld_data    = opening ? hdr_rest : in_data;

  srp_path_lock #(.PORT_W(PORT_W)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .open_i      (opening),
    .open_port_i (hdr_port),
    .close_i     (closing),
    .locked_o    (locked),
    .port_o      (out_port),
    .req_o       (req_vec)
  );

  srp_flit_stage #(.FLIT_W(FLIT_W), .TYPE_W(TYPE_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .data_i  (ld_data),
    .type_i  (in_type),
    .pop_i   (fire),
    .valid_o (out_valid),
    .data_o  (out_data),
    .type_o  (out_type)
  );

  // R2: a held flit always has its output requested
  p_valid_has_req_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> req_vec[out_port]);

  // R7: tail leaving with no new head frees the request
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (closing && !opening) |=> (req_vec == '0));

  // R9: stray flit on an idle port leaves nothing to forward
  p_stray_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && !lock_after && !is_head(in_type) && !out_valid) |=> !out_valid);
endmodule

// File: tb/srp_inport_tb.sv
`timescale 1ns/1ps
module srp_inport_tb_top;
  localparam int FW = 32;
  localparam int PW = 4;
  localparam int NP = 1 << PW;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, in_valid, in_ready, out_valid, out_ready;
  logic [1:0]    in_type, out_type;
  logic [FW-1:0] in_data, out_data;
  logic [NP-1:0] req_vec, grant_vec;
  logic [PW-1:0] out_port;

  srp_inport #(.FLIT_W(FW), .PORT_W(PW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_data(in_data), .req_vec(req_vec),
    .grant_vec(grant_vec), .out_valid(out_valid), .out_ready(out_ready),
    .out_type(out_type), .out_data(out_data), .out_port(out_port)
  );

  typedef struct { logic [FW-1:0] d; logic [1:0] t; } src_t;
  typedef struct { logic [FW-1:0] d; logic [1:0] t; int p; string tag; } exp_t;

  src_t sq[$];
  exp_t eq[$];
  int errs = 0, checks = 0, cyc = 0, drops = 0;
  int gmode = 0, rmode = 0, vprob = 100;
  bit mlock = 0;
  int mport = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural model of an accepted input flit
  task automatic absorb(src_t f);
    exp_t e;
    if (!mlock) begin
      if (f.t[0]) begin
        e.d = f.d >> PW; e.t = f.t; e.p = int'(f.d[PW-1:0]);
        e.tag = f.t[1] ? "R8" : "R3";
        eq.push_back(e);
        mlock = !f.t[1];
        mport = e.p;
      end else drops++;
    end else begin
      e.d = f.d; e.t = f.t; e.p = mport; e.tag = "R4";
      eq.push_back(e);
      if (f.t[1]) mlock = 0;
    end
  endtask

  task automatic step();
    logic [NP-1:0] er;
    logic fx, eir;
    @(negedge clk);
    cyc++;
    if (sq.size() > 0 && $urandom_range(99) < vprob) begin
      in_valid = 1'b1; in_data = sq[0].d; in_type = sq[0].t;
    end else begin
      in_valid = 1'b0; in_data = '0; in_type = '0;
    end
    out_ready = (rmode == 0) ? 1'b1 : ($urandom_range(2) != 0);
    case (gmode)
      0: grant_vec = req_vec;
      1: grant_vec = ($urandom_range(1) != 0) ? req_vec : '0;
      default: grant_vec = {req_vec[NP-2:0], req_vec[NP-1]};
    endcase
    #3;
    er = '0;
    if (eq.size() > 0) er[eq[0].p] = 1'b1;
    else if (mlock) er[mport] = 1'b1;
    fx  = (eq.size() > 0) && grant_vec[eq[0].p] && out_ready;
    eir = (eq.size() == 0) || fx;
    chk(req_vec == er, "R2 R7", "req_vec", longint'(req_vec), longint'(er));
    chk(in_ready == eir, "R10", "in_ready", longint'(in_ready), longint'(eir));
    if (eq.size() > 0) begin
      chk(out_valid == 1'b1, "R6", "out_valid", longint'(out_valid), 1);
      chk(out_data == eq[0].d, eq[0].tag, "out_data", longint'(out_data), longint'(eq[0].d));
      chk(out_type == eq[0].t, "R5", "out_type", longint'(out_type), longint'(eq[0].t));
      chk(int'(out_port) == eq[0].p, "R11", "out_port", longint'(out_port), longint'(eq[0].p));
    end else begin
      chk(out_valid == 1'b0, "R9", "out_valid idle", longint'(out_valid), 0);
    end
    if (fx) void'(eq.pop_front());
    if (in_valid && in_ready) absorb(sq.pop_front());
  endtask

  task automatic put(logic [FW-1:0] d, logic [1:0] t);
    src_t f; f.d = d; f.t = t; sq.push_back(f);
  endtask

  // nbody < 0 gives a single-flit packet
  task automatic pkt(logic [FW-1:0] route, int nbody);
    if (nbody < 0) put(route, 2'b11);
    else begin
      put(route, 2'b01);
      for (int i = 0; i < nbody; i++) put(FW'($urandom), 2'b00);
      put(FW'($urandom), 2'b10);
    end
  endtask

  task automatic drain();
    while ((sq.size() > 0 || eq.size() > 0) && cyc < LIMIT) step();
    step();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_type = '0; in_data = '0;
    grant_vec = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #3;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
    chk(req_vec == '0, "R1", "req_vec", longint'(req_vec), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);

    // plain streaming, back to back
    pkt(32'h8765_4323, 3); pkt(32'h0000_00A7, 0); pkt(32'hFFFF_FFFF, 5);
    drain();

    // R8 single-flit packets back to back, including port 0 and port 15
    pkt(32'h1234_5670, -1); pkt(32'hABCD_EF0F, -1); pkt(32'h0000_0005, -1);
    pkt(32'h0000_0039, 2);
    drain();

    // R9 stray body and tail with no path, then a real packet
    put(32'hDEAD_BEEF, 2'b00); put(32'hCAFE_F00D, 2'b10);
    drain();
    chk(drops == 2, "R9", "stray flits dropped", drops, 2);
    chk(out_valid == 1'b0, "R9", "nothing forwarded", longint'(out_valid), 0);
    pkt(32'h0000_0C4B, 1);
    drain();

    // R4 head-marked flit inside a locked packet passes raw
    put(32'h0000_00E2, 2'b01); put(32'h5555_5551, 2'b01); put(32'h7777_7773, 2'b10);
    drain();

    // R6 grant only on a wrong output: packet must freeze
    gmode = 2;
    pkt(32'h0000_0096, 2);
    run(25);
    chk(eq.size() == 1, "R6", "frozen stage depth", eq.size(), 1);
    gmode = 0;
    drain();

    // random stalls on grant, ready and input valid
    gmode = 1; rmode = 1; vprob = 70;
    for (int k = 0; k < 60; k++) begin
      int nb = int'($urandom_range(4)) - 1;
      pkt(FW'($urandom), nb);
      if (k % 7 == 3) put(FW'($urandom), 2'b00);
      drain();
    end
    // tail leaving while next head arrives, under stalls
    vprob = 100;
    for (int k = 0; k < 30; k++) pkt(FW'($urandom), k % 3 - 1);
    drain();

    if (cyc >= LIMIT) chk(1'b0, "R6", "watchdog expired", cyc, LIMIT);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule